// File: doc/BRIEF.md
# DAC Output-Stage Switch Sequencer

This block drives the six transmission-gate enables of one converter channel's output stage. It decides which gates are closed from two inputs. The first is a flag that rises once the analog supplies have enough headroom. The second is an active-low clear level. While the supplies are low, the amplifier runs as a unity buffer. A resistor ties its output to the ground-sense pin, and the converter or the ground-sense voltage feeds its input. Once the supplies are ready, the block hands over to the gain configuration. There, clear low makes the output follow ground sense, and clear high gives a noninverting gain-of-two path from the converter.

Both inputs are asynchronous and pass through a synchronizer. Every reconfiguration that closes a gate is preceded by one cycle in which only the gates that must open have opened. Because of this, no two conflicting gates ever conduct together. A synchronous reset stands for power application and returns the stage to the clear-low buffer setting.

Gate enable bit i of `gate_on_o` is gate G(i+1): bit 0 is the converter feed, bit 1 the ground-sense feed, bit 2 the unity feedback, bit 3 the gain feedback, bit 4 the resistive tie, bit 5 the gain-resistor ground.

Top module: `dac_outsw_seq`

## Requirements
- R1: During reset and afterwards, while supply ready and clear are both low, `gate_on_o` is 6'b010110 (G2, G3, G5 closed) and `phase_o` is 0. Reset takes effect at the first clock edge at which `rst` is high, from any state.
- R2: With supply not ready and clear high, `gate_on_o` settles to 6'b010101 (G1, G3, G5) and `phase_o` to 1.
- R3: With supply ready and clear low, `gate_on_o` settles to 6'b101010 (G2, G4, G6) and `phase_o` to 2, so the output follows ground sense through the gain path.
- R4: With supply ready and clear high, `gate_on_o` settles to 6'b101001 (G1, G4, G6) and `phase_o` to 3.
- R5: G1 and G2 are never closed in the same cycle, and neither are G3 and G4.
- R6: Outside reset, a change of `gate_on_o` that closes any gate never opens a gate at the same edge. When the old and new settings differ both ways, the block holds, for exactly one cycle, the intersection of the two settings, with `phase_o` = 4.
- R7: An input change held stable is first seen on `gate_on_o` SYNC_STAGES+1 clock edges after it is sampled. The new setting is complete one edge later. With the default of 2 stages this is 4 edges (16 ns at 250 MHz), well inside the 300 ns allowed for clear.
- R8: If supply ready falls after power-up, the block returns to the not-ready setting that matches the current clear level.
- R9: A clear pulse that lasts one clock cycle in the gain-high setting produces the one-cycle break pattern 6'b101000. The block then returns to 6'b101001 without ever closing G2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous reset, active high, models power application |
| supply_ok_i | input | 1 | Asynchronous flag, high once the analog supplies are ready |
| clr_n_i | input | 1 | Asynchronous clear level, active low |
| gate_on_o | output | 6 | Gate closed enables, bit i = G(i+1) |
| phase_o | output | 3 | 0 buffer/clear, 1 buffer/run, 2 gain/clear, 3 gain/run, 4 break cycle |

## Verification
The bench walks through every handover: power-good in either clear level, clear entry and exit in the gain setting, supply loss in both clear levels, and both inputs changing at once. A design that skipped the break cycle would show a cycle with G1 and G2 closed together, or with G3 and G4. A design with the wrong synchronizer depth would move the changes to other cycles. Reset applied from the gain setting must jump back to the buffer setting at once. A one-cycle clear pulse must show only the break pattern, because a design that latched the pulse would close G2. When both inputs change together, the old and new settings share no closed gate, so the break cycle must open every gate. A design that took the intersection wrongly would leave a gate closed there.

// File: rtl/dac_outsw_pkg.sv
package dac_outsw_pkg;

  localparam int unsigned NUM_GATES = 6;
  localparam int unsigned IDX_G1 = 0;
  localparam int unsigned IDX_G2 = 1;
  localparam int unsigned IDX_G3 = 2;
  localparam int unsigned IDX_G4 = 3;
  localparam int unsigned IDX_G5 = 4;
  localparam int unsigned IDX_G6 = 5;

  typedef logic [NUM_GATES-1:0] gate_vec_t;

  typedef enum logic [2:0] {
    PH_BOOT_CLR = 3'd0,
    PH_BOOT_RUN = 3'd1,
    PH_GAIN_CLR = 3'd2,
    PH_GAIN_RUN = 3'd3,
    PH_BREAK    = 3'd4
  } phase_e;

  // Gate setting for each steady phase; the break phase has no fixed pattern.
  function automatic gate_vec_t phase_pattern(phase_e ph);
    gate_vec_t v;
    v = '0;
    case (ph)
      PH_BOOT_CLR: begin v[IDX_G2] = 1'b1; v[IDX_G3] = 1'b1; v[IDX_G5] = 1'b1; end
      PH_BOOT_RUN: begin v[IDX_G1] = 1'b1; v[IDX_G3] = 1'b1; v[IDX_G5] = 1'b1; end
      PH_GAIN_CLR: begin v[IDX_G2] = 1'b1; v[IDX_G4] = 1'b1; v[IDX_G6] = 1'b1; end
      PH_GAIN_RUN: begin v[IDX_G1] = 1'b1; v[IDX_G4] = 1'b1; v[IDX_G6] = 1'b1; end
      default:     v = '0;
    endcase
    return v;
  endfunction

  // Steady phase wanted for a given supply readiness and clear level.
  function automatic phase_e select_phase(logic rdy, logic clr_n);
    if (rdy) return clr_n ? PH_GAIN_RUN : PH_GAIN_CLR;
    return clr_n ? PH_BOOT_RUN : PH_BOOT_CLR;
  endfunction

endpackage

// File: rtl/dac_outsw_sync.sv
module dac_outsw_sync #(
  parameter int unsigned WIDTH  = 2,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
    end
  end

  assign q_o = chain_q[LAST];

endmodule

// File: rtl/dac_outsw_target.sv
module dac_outsw_target
  import dac_outsw_pkg::*;
(
  input  logic      rdy_i,
  input  logic      clr_n_i,
  output phase_e    tgt_phase_o,
  output gate_vec_t tgt_gates_o
);

  always_comb begin
    tgt_phase_o = select_phase(rdy_i, clr_n_i);
    tgt_gates_o = phase_pattern(tgt_phase_o);
  end

endmodule

// File: rtl/dac_outsw_bbm.sv
module dac_outsw_bbm
  import dac_outsw_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  phase_e    tgt_phase_i,
  input  gate_vec_t tgt_gates_i,
  output gate_vec_t gates_o,
  output phase_e    phase_o
);

  gate_vec_t gate_q;
  phase_e    phase_q;
  gate_vec_t opening_w;
  gate_vec_t closing_w;
  logic      need_gap_w;
  gate_vec_t next_gates_w;
  phase_e    next_phase_w;

  assign opening_w  = gate_q & ~tgt_gates_i;
  assign closing_w  = tgt_gates_i & ~gate_q;
  assign need_gap_w = (|opening_w) && (|closing_w);

  always_comb begin
    if (need_gap_w) begin
      next_gates_w = gate_q & tgt_gates_i;
      next_phase_w = PH_BREAK;
    end else begin
      next_gates_w = tgt_gates_i;
      next_phase_w = tgt_phase_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q  <= phase_pattern(PH_BOOT_CLR);
      phase_q <= PH_BOOT_CLR;
    end else begin
      gate_q  <= next_gates_w;
      phase_q <= next_phase_w;
    end
  end

  assign gates_o = gate_q;
  assign phase_o = phase_q;

  // History for the edge-to-edge checks below.
  gate_vec_t prev_gates_q;
  logic      hist_valid_q;

  always_ff @(posedge clk) begin
    prev_gates_q <= gate_q;
    hist_valid_q <= !rst;
  end

  assert_g1_g2_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(gate_q[IDX_G1] && gate_q[IDX_G2]));

  assert_g3_g4_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(gate_q[IDX_G3] && gate_q[IDX_G4]));

  assert_break_first_R6: assert property (@(posedge clk) disable iff (rst)
    (hist_valid_q && (|(gate_q & ~prev_gates_q))) |-> !(|(prev_gates_q & ~gate_q)));

  assert_phase_gates_R2: assert property (@(posedge clk) disable iff (rst)
    (phase_q != PH_BREAK) |-> (gate_q == phase_pattern(phase_q)));

endmodule

// File: rtl/dac_outsw_seq.sv
module dac_outsw_seq
  import dac_outsw_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       supply_ok_i,
  input  logic       clr_n_i,
  output logic [5:0] gate_on_o,
  output logic [2:0] phase_o
);

  logic [1:0] sync_w;
  logic       rdy_s;
  logic       clr_n_s;
  phase_e     tgt_phase_w;
  gate_vec_t  tgt_gates_w;
  gate_vec_t  gates_w;
  phase_e     phase_w;

  // Reset value: supply not ready, clear asserted.
  dac_outsw_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({supply_ok_i, clr_n_i}),
    .q_o (sync_w)
  );

  assign rdy_s   = sync_w[1];
  assign clr_n_s = sync_w[0];

  dac_outsw_target u_target (
    .rdy_i       (rdy_s),
    .clr_n_i     (clr_n_s),
    .tgt_phase_o (tgt_phase_w),
    .tgt_gates_o (tgt_gates_w)
  );

  dac_outsw_bbm u_bbm (
    .clk         (clk),
    .rst         (rst),
    .tgt_phase_i (tgt_phase_w),
    .tgt_gates_i (tgt_gates_w),
    .gates_o     (gates_w),
    .phase_o     (phase_w)
  );

  assign gate_on_o = gates_w;
  assign phase_o   = phase_w;

  logic hist_q;
  always_ff @(posedge clk) hist_q <= !rst;

  assert_gain_needs_ready_R3: assert property (@(posedge clk) disable iff (rst)
    (hist_q && (phase_w == PH_GAIN_CLR || phase_w == PH_GAIN_RUN)) |-> $past(rdy_s));

  assert_clear_ties_ground_R8: assert property (@(posedge clk) disable iff (rst)
    (hist_q && (phase_w == PH_BOOT_CLR || phase_w == PH_GAIN_CLR)) |-> !$past(clr_n_s));

  assert_run_needs_release_R4: assert property (@(posedge clk) disable iff (rst)
    (hist_q && (phase_w == PH_BOOT_RUN || phase_w == PH_GAIN_RUN)) |-> $past(clr_n_s));

endmodule

// File: tb/dac_outsw_seq_tb.sv
module dac_outsw_seq_tb;

  localparam logic [5:0] P_BC = 6'b010110;
  localparam logic [5:0] P_BR = 6'b010101;
  localparam logic [5:0] P_GC = 6'b101010;
  localparam logic [5:0] P_GR = 6'b101001;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       supply_ok = 1'b0;
  logic       clr_n = 1'b0;
  logic [5:0] gate_on;
  logic [2:0] phase;

  int checks = 0;
  int failures = 0;
  int excl_viol = 0;
  int bbm_viol = 0;
  logic done = 1'b0;

  always #2 clk = ~clk;

  dac_outsw_seq u_dut (
    .clk         (clk),
    .rst         (rst),
    .supply_ok_i (supply_ok),
    .clr_n_i     (clr_n),
    .gate_on_o   (gate_on),
    .phase_o     (phase)
  );

  // Continuous monitors for R5 and R6, sampled at falling edges.
  logic [5:0] mon_prev = P_BC;
  logic       mon_skip = 1'b1;
  always @(negedge clk) begin
    if ((gate_on[0] && gate_on[1]) || (gate_on[2] && gate_on[3])) excl_viol++;
    if (!mon_skip && !rst && (|(gate_on & ~mon_prev)) && (|(mon_prev & ~gate_on))) bbm_viol++;
    mon_prev = gate_on;
    mon_skip = rst;
  end

  task automatic check(string req, logic [5:0] exp_g, logic [2:0] exp_ph);
    checks++;
    if (gate_on !== exp_g || phase !== exp_ph) begin
      failures++;
      $display("FAIL %s gates=%b phase=%0d expected gates=%b phase=%0d",
               req, gate_on, phase, exp_g, exp_ph);
    end
  endtask

  task automatic drive(logic rdy, logic cn);
    @(negedge clk);
    supply_ok = rdy;
    clr_n = cn;
  endtask

  task automatic edges(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Drive a change, then check the old setting, the break cycle and the new setting.
  task automatic transition(string req, logic rdy, logic cn,
                            logic [5:0] old_g, logic [5:0] new_g, logic [2:0] new_ph);
    logic gap;
    gap = (|(old_g & ~new_g)) && (|(new_g & ~old_g));
    drive(rdy, cn);
    edges(2);
    check({req, " R7 latency hold"}, old_g, 3'(u_dut.phase_o));
    edges(1);
    if (gap) check({req, " R6 break"}, old_g & new_g, 3'd4);
    else     check({req, " R7 direct"}, new_g, new_ph);
    edges(1);
    check({req, " final"}, new_g, new_ph);
  endtask

  task automatic t_reset;
    supply_ok = 1'b1; clr_n = 1'b1; rst = 1'b1;
    edges(3);
    check("R1 during reset", P_BC, 3'd0);
    drive(1'b0, 1'b0);
    rst = 1'b0;
    edges(6);
    check("R1 after release", P_BC, 3'd0);
  endtask

  task automatic t_boot_run;
    transition("R2 clear release unpowered", 1'b0, 1'b1, P_BC, P_BR, 3'd1);
  endtask

  task automatic t_power_good;
    transition("R4 power good run", 1'b1, 1'b1, P_BR, P_GR, 3'd3);
  endtask

  task automatic t_clear_cycle;
    transition("R3 clear entry", 1'b1, 1'b0, P_GR, P_GC, 3'd2);
    transition("R4 clear exit", 1'b1, 1'b1, P_GC, P_GR, 3'd3);
  endtask

  task automatic t_supply_drop;
    transition("R8 drop run", 1'b0, 1'b1, P_GR, P_BR, 3'd1);
    transition("R4 regain", 1'b1, 1'b1, P_BR, P_GR, 3'd3);
    transition("R3 clear", 1'b1, 1'b0, P_GR, P_GC, 3'd2);
    transition("R8 drop clear", 1'b0, 1'b0, P_GC, P_BC, 3'd0);
    transition("R3 power good clear", 1'b1, 1'b0, P_BC, P_GC, 3'd2);
  endtask

  task automatic t_mid_reset;
    transition("R4 before reset", 1'b1, 1'b1, P_GC, P_GR, 3'd3);
    @(negedge clk);
    rst = 1'b1;
    edges(1);
    check("R1 reset from gain", P_BC, 3'd0);
    supply_ok = 1'b0; clr_n = 1'b0;
    edges(1);
    rst = 1'b0;
    edges(4);
    check("R1 idle after reset", P_BC, 3'd0);
  endtask

  task automatic t_both_change;
    transition("R6 both inputs", 1'b1, 1'b1, P_BC, P_GR, 3'd3);
  endtask

  task automatic t_short_clear;
    @(negedge clk);
    clr_n = 1'b0;
    @(negedge clk);
    clr_n = 1'b1;
    // Pulse sampled at one edge; break visible three edges after that edge.
    edges(2);
    check("R9 pulse break", 6'b101000, 3'd4);
    edges(1);
    check("R9 pulse return", P_GR, 3'd3);
    edges(5);
    check("R9 settled", P_GR, 3'd3);
  endtask

  initial begin
    t_reset();
    t_boot_run();
    t_power_good();
    t_clear_cycle();
    t_supply_drop();
    t_mid_reset();
    t_both_change();
    t_short_clear();
    checks++;
    if (excl_viol != 0) begin
      failures++;
      $display("FAIL R5 exclusive pairs violations=%0d expected=0", excl_viol);
    end
    checks++;
    if (bbm_viol != 0) begin
      failures++;
      $display("FAIL R6 same-step open/close violations=%0d expected=0", bbm_viol);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog run incomplete actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule